// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a link to a small serial EEPROM that uses a chip select, a shift clock and one data line in each direction. A system-side agent hands it one command at a time over a valid/ready pair. Each command carries a command kind, a word address, write data and an organisation select (byte words or 16-bit words). The controller then builds the serial instruction, clocks it out MSB first and, for reads, clocks the data word back in. At completion it gives a one-cycle done pulse with the read word and an error flag.

For commands that program the array, the controller does not wait for a fixed worst-case time. It drops chip select for a short gap, raises it again and watches the returned data line. A low level means the device is still busy and a high level means it has finished. If the high level does not arrive within a bounded number of cycles, the command ends with the error flag set. The serial clock is derived from the system clock by a half-period divider parameter. The defaults give phases of at least 250 ns from a 250 MHz clock, and a poll limit of about 10 ms.

The control is one state machine with these states:
- ST_IDLE: accepts a request.
- ST_SEND: shifts out the instruction.
- ST_RECV: clocks in the dummy bit and the data word.
- ST_SETTLE: chip select low before a status poll.
- ST_POLL: chip select high, watching for ready.
- ST_CLOSE: chip select low before signalling done.

The transitions are:
- ST_IDLE→ST_SEND on an accepted request.
- ST_SEND→ST_RECV for a read.
- ST_SEND→ST_SETTLE for a programming command.
- ST_SEND→ST_CLOSE for unlock or lock.
- ST_RECV→ST_CLOSE after the last data bit.
- ST_SETTLE→ST_POLL when the gap ends.
- ST_POLL→ST_CLOSE on ready or on timeout.
- ST_CLOSE→ST_IDLE with the done pulse.

Top module: `ser_eeprom_host`

## Requirements
- R1: After reset, and whenever the controller is idle, req_ready is 1 and mem_cs, mem_sk and rsp_done are 0. A request is taken only in a cycle where req_valid and req_ready are both 1. From then until rsp_done, req_ready stays 0.
- R2: Each high phase and each low phase of mem_sk lasts exactly CLK_DIV system clocks. mem_sk is 0 whenever mem_cs is 0, and it is 0 in the cycle mem_cs rises. mem_do does not change while mem_sk is high.
- R3: req_cmd encodes the commands as follows: 0 read, 1 write, 2 erase one word, 3 erase all, 4 write all, 5 unlock, 6 lock. Every instruction is sent MSB first on rising mem_sk edges in this order: a 1 start bit, a 2-bit opcode, then the address field. The opcode is 10 for read, 01 for write, 11 for erase one, and 00 for the rest. The address field is 7 bits when req_wide=0 and 6 bits when req_wide=1. For write and write-all, 8 data bits (req_wide=0) or 16 data bits (req_wide=1) follow.
- R4: For the opcode-00 commands, the top two address-field bits carry a sub-code: unlock 11, erase-all 10, write-all 01, lock 00. All remaining address bits are 0, and the full address-field length is still clocked.
- R5: A read clocks 9 (byte) or 17 (word) further mem_sk cycles after the address and samples mem_di at the end of each high phase. The first sample is discarded. The rest form rsp_rdata, MSB first, right-aligned and zero-extended.
- R6: After write, erase one, erase all and write all, mem_cs is held 0 for exactly CS_LOW_CYC clocks. It is then driven 1, and the command completes in the first cycle in which mem_di is 1.
- R7: If mem_di stays 0 for POLL_LIMIT cycles with mem_cs high, mem_cs returns to 0 and the command finishes with rsp_err=1.
- R8: rsp_done is a one-cycle pulse, raised only after mem_cs has been 0 for CS_LOW_CYC clocks. rsp_err is 1 only together with rsp_done. rsp_rdata holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_cmd | input | 3 | Command kind (encoding in R3) |
| req_addr | input | ADDR_W | Word address (low 6 bits used in word mode) |
| req_wdata | input | DATA_W | Write data (low 8 bits used in byte mode) |
| req_wide | input | 1 | 1 selects 16-bit words, 0 selects byte words |
| rsp_rdata | output | DATA_W | Word returned by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Status-poll timeout, valid with rsp_done |
| mem_cs | output | 1 | Chip select to the memory |
| mem_sk | output | 1 | Serial shift clock to the memory |
| mem_do | output | 1 | Serial data to the memory |
| mem_di | input | 1 | Serial data and ready status from the memory |

## Verification
A wrong bit counter or a wrong frame length shows at the ports within the same command. The number of mem_sk rising edges changes, and the memory model on the far side decodes the wrong opcode, sub-code or address. That corrupts the word read back by a later read. A slip in the read capture, such as keeping the dummy bit, shifts every returned word by one position at the first read. A poll or gap counter that is off shows as a mem_cs low or high run of the wrong length, measured in clocks on the command that used it.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;

    typedef enum logic [2:0] {
        CMD_RD       = 3'd0,
        CMD_WR       = 3'd1,
        CMD_CLR      = 3'd2,
        CMD_CLR_ALL  = 3'd3,
        CMD_FILL_ALL = 3'd4,
        CMD_UNLOCK   = 3'd5,
        CMD_LOCK     = 3'd6
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_RECV,
        ST_SETTLE,
        ST_POLL,
        ST_CLOSE
    } state_e;

    // Opcode bits as the memory decodes them
    function automatic logic [1:0] opcode_of(cmd_e c);
        case (c)
            CMD_RD:  return 2'b10;
            CMD_WR:  return 2'b01;
            CMD_CLR: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    // Sub-code placed in the top two address bits of opcode-00 commands
    function automatic logic [1:0] subcode_of(cmd_e c);
        case (c)
            CMD_UNLOCK:   return 2'b11;
            CMD_CLR_ALL:  return 2'b10;
            CMD_FILL_ALL: return 2'b01;
            default:      return 2'b00;
        endcase
    endfunction

    function automatic logic carries_data(cmd_e c);
        return (c == CMD_WR) || (c == CMD_FILL_ALL);
    endfunction

    function automatic logic needs_poll(cmd_e c);
        return (c == CMD_WR) || (c == CMD_CLR) || (c == CMD_CLR_ALL) || (c == CMD_FILL_ALL);
    endfunction

endpackage

// File: rtl/ser_eeprom_timer.sv
module ser_eeprom_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || expire)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/ser_eeprom_frame.sv
module ser_eeprom_frame
    import ser_eeprom_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 3 + ADDR_W + DATA_W,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  cmd_e                cmd,
    input  logic                wide,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [FRAME_W-1:0]  frame,
    output logic [LEN_W-1:0]    len
);
    always_comb begin
        int abits;
        int dbits;
        int nbits;
        logic [FRAME_W-1:0] acc;
        logic [ADDR_W-1:0]  afield;
        logic [DATA_W-1:0]  dfield;

        abits = wide ? ADDR_W - 1 : ADDR_W;
        dbits = wide ? DATA_W : DATA_W / 2;

        if (opcode_of(cmd) == 2'b00)
            afield = ADDR_W'(subcode_of(cmd)) << (abits - 2);
        else
            afield = addr & ((ADDR_W'(1) << abits) - ADDR_W'(1));
        dfield = wdata & ((DATA_W'(1) << dbits) - DATA_W'(1));

        acc   = FRAME_W'(1);
        acc   = (acc << 2) | FRAME_W'(opcode_of(cmd));
        acc   = (acc << abits) | FRAME_W'(afield);
        nbits = 3 + abits;
        if (carries_data(cmd)) begin
            acc   = (acc << dbits) | FRAME_W'(dfield);
            nbits = nbits + dbits;
        end

        frame = acc << (FRAME_W - nbits);
        len   = LEN_W'(nbits);
    end
endmodule

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host
    import ser_eeprom_pkg::*;
#(
    parameter int CLK_DIV    = 63,
    parameter int CS_LOW_CYC = 63,
    parameter int POLL_LIMIT = 2_500_000,
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_wide,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic              mem_cs,
    output logic              mem_sk,
    output logic              mem_do,
    input  logic              mem_di
);
    localparam int FRAME_W = 3 + ADDR_W + DATA_W;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    state_e state, state_nx;

    logic [FRAME_W-1:0] frame_new;
    logic [LEN_W-1:0]   len_new;
    logic [FRAME_W-1:0] shreg;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   bitn;
    logic [LEN_W-1:0]   rd_last;
    cmd_e               cmd_q;
    logic               wide_q;
    logic               cs_q;
    logic               sk_q;
    logic               tout_q;
    logic               done_q;
    logic               err_q;
    logic [DATA_W-1:0]  rdata_q;

    logic half_end, gap_end, poll_end;
    logic send_last, recv_last;

    ser_eeprom_frame #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .LEN_W  (LEN_W)
    ) u_frame (
        .cmd  (cmd_e'(req_cmd)),
        .wide (req_wide),
        .addr (req_addr),
        .wdata(req_wdata),
        .frame(frame_new),
        .len  (len_new)
    );

    ser_eeprom_timer #(.LIMIT(CLK_DIV)) u_half (
        .clk(clk), .rst_n(rst_n),
        .run((state == ST_SEND) || (state == ST_RECV)),
        .expire(half_end)
    );

    ser_eeprom_timer #(.LIMIT(CS_LOW_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n),
        .run((state == ST_SETTLE) || (state == ST_CLOSE)),
        .expire(gap_end)
    );

    ser_eeprom_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst_n(rst_n),
        .run(state == ST_POLL),
        .expire(poll_end)
    );

    assign rd_last   = wide_q ? LEN_W'(DATA_W) : LEN_W'(DATA_W / 2);
    assign send_last = half_end && sk_q && (bitn == len_q - LEN_W'(1));
    assign recv_last = half_end && sk_q && (bitn == rd_last);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_SEND;
            ST_SEND:   if (send_last) begin
                           if (cmd_q == CMD_RD)       state_nx = ST_RECV;
                           else if (needs_poll(cmd_q)) state_nx = ST_SETTLE;
                           else                       state_nx = ST_CLOSE;
                       end
            ST_RECV:   if (recv_last) state_nx = ST_CLOSE;
            ST_SETTLE: if (gap_end) state_nx = ST_POLL;
            ST_POLL:   if (mem_di || poll_end) state_nx = ST_CLOSE;
            ST_CLOSE:  if (gap_end) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            len_q   <= '0;
            bitn    <= '0;
            cmd_q   <= CMD_RD;
            wide_q  <= 1'b0;
            cs_q    <= 1'b0;
            sk_q    <= 1'b0;
            tout_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        shreg  <= frame_new;
                        len_q  <= len_new;
                        bitn   <= '0;
                        cmd_q  <= cmd_e'(req_cmd);
                        wide_q <= req_wide;
                        cs_q   <= 1'b1;
                        sk_q   <= 1'b0;
                        tout_q <= 1'b0;
                        if (cmd_e'(req_cmd) == CMD_RD)
                            rdata_q <= '0;
                    end
                end
                ST_SEND: begin
                    if (half_end) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                        end else begin
                            sk_q  <= 1'b0;
                            shreg <= shreg << 1;
                            bitn  <= bitn + LEN_W'(1);
                            if (send_last) begin
                                bitn <= '0;
                                if (cmd_q != CMD_RD)
                                    cs_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_RECV: begin
                    if (half_end) begin
                        if (!sk_q) begin
                            sk_q <= 1'b1;
                        end else begin
                            sk_q <= 1'b0;
                            bitn <= bitn + LEN_W'(1);
                            if (bitn != '0)
                                rdata_q <= {rdata_q[DATA_W-2:0], mem_di};
                            if (recv_last)
                                cs_q <= 1'b0;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (gap_end)
                        cs_q <= 1'b1;
                end
                ST_POLL: begin
                    if (mem_di) begin
                        cs_q <= 1'b0;
                    end else if (poll_end) begin
                        cs_q   <= 1'b0;
                        tout_q <= 1'b1;
                    end
                end
                ST_CLOSE: begin
                    if (gap_end) begin
                        done_q <= 1'b1;
                        err_q  <= tout_q;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_done  = done_q;
    assign rsp_err   = err_q;
    assign rsp_rdata = rdata_q;
    assign mem_cs    = cs_q;
    assign mem_sk    = sk_q;
    assign mem_do    = (state == ST_SEND) ? shreg[FRAME_W-1] : 1'b0;

endmodule

// File: rtl/ser_eeprom_host_chk.sv
module ser_eeprom_host_chk #(
    parameter int CLK_DIV = 63
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_done,
    input logic rsp_err,
    input logic mem_cs,
    input logic mem_sk,
    input logic mem_do
);
    localparam int HW = $clog2(CLK_DIV + 2);

    logic          sk_prev;
    logic [HW-1:0] hold;

    // Cycles since mem_sk last changed, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_prev <= 1'b0;
            hold    <= '0;
        end else begin
            sk_prev <= mem_sk;
            if (mem_sk != sk_prev)
                hold <= '0;
            else if (hold != {HW{1'b1}})
                hold <= hold + HW'(1);
        end
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_cs && !mem_sk));

    assert_sk_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sk |-> mem_cs);

    assert_cs_rise_sk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs) |-> !mem_sk);

    assert_do_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sk && $past(mem_sk)) |-> $stable(mem_do));

    assert_high_phase_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_prev && !mem_sk) |-> (hold == HW'(CLK_DIV - 1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    assert_done_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && !mem_cs));

endmodule

bind ser_eeprom_host ser_eeprom_host_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err),
    .mem_cs   (mem_cs),
    .mem_sk   (mem_sk),
    .mem_do   (mem_do)
);

// File: tb/ser_eeprom_host_bench.sv
module ser_eeprom_host_bench;
    localparam int CLK_DIV    = 2;
    localparam int CS_LOW_CYC = 3;
    localparam int POLL_LIMIT = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic [6:0]  req_addr = 7'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        req_wide = 1'b0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_err;
    logic        mem_cs, mem_sk, mem_do, mem_di;

    always #2 clk = ~clk;

    ser_eeprom_host #(
        .CLK_DIV(CLK_DIV), .CS_LOW_CYC(CS_LOW_CYC), .POLL_LIMIT(POLL_LIMIT),
        .ADDR_W(7), .DATA_W(16)
    ) u_ser_eeprom_host (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wide(req_wide),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_do(mem_do), .mem_di(mem_di)
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- memory model ----------------
    logic [7:0]  memm [128];
    logic [31:0] shv;
    logic [16:0] rstream;
    logic        dout = 1'b0;
    bit          reading = 0, en = 0, inited = 0, pend_wr = 0, pend_fill = 0;
    int          nb = 0, ridx = 0, prog_seq = 0, tot_edges = 0;
    int          cap_start = 0, cap_op = 0, cap_addr = 0, cap_a = 0;
    int          busy_len = 4, busy_cnt = 0, seen_seq = 0;

    assign mem_di = reading ? dout : (busy_cnt == 0);

    always @(posedge mem_sk or posedge mem_cs) begin
        int ab, db, dat;
        ab = req_wide ? 6 : 7;
        db = req_wide ? 16 : 8;
        if (!mem_sk) begin
            if (!inited) begin
                for (int i = 0; i < 128; i++) memm[i] = 8'((i * 3 + 1) & 255);
                inited = 1;
            end
            nb = 0; reading = 0; shv = 0; pend_wr = 0; pend_fill = 0;
        end else begin
            tot_edges++;
            if (reading) begin
                dout <= rstream[db - ridx];
                ridx++;
            end
            shv = (shv << 1) | 32'(mem_do);
            nb++;
            if (nb == 3 + ab) begin
                cap_start = int'(shv[2 + ab]);
                cap_op    = int'((shv >> ab) & 3);
                cap_addr  = int'(shv & ((32'd1 << ab) - 1));
                cap_a     = cap_addr;
                case (cap_op)
                    2: begin
                        reading = 1; ridx = 0;
                        rstream = req_wide ? {1'b0, memm[2*cap_a], memm[2*cap_a+1]}
                                           : {9'd0, memm[cap_a]};
                    end
                    3: if (en) begin
                        if (req_wide) begin memm[2*cap_a] = 8'hFF; memm[2*cap_a+1] = 8'hFF; end
                        else memm[cap_a] = 8'hFF;
                        prog_seq++;
                    end
                    1: pend_wr = 1;
                    default: case (cap_addr >> (ab - 2))
                        3: en = 1;
                        0: en = 0;
                        2: if (en) begin
                            for (int i = 0; i < 128; i++) memm[i] = 8'hFF;
                            prog_seq++;
                        end
                        default: pend_fill = 1;
                    endcase
                endcase
            end else if (nb == 3 + ab + db && (pend_wr || pend_fill)) begin
                dat = int'(shv & ((32'd1 << db) - 1));
                if (en) begin
                    if (pend_wr) begin
                        if (req_wide) begin
                            memm[2*cap_a] = 8'(dat >> 8); memm[2*cap_a+1] = 8'(dat);
                        end else memm[cap_a] = 8'(dat);
                    end else begin
                        for (int i = 0; i < 128; i++)
                            memm[i] = req_wide ? ((i % 2 == 0) ? 8'(dat >> 8) : 8'(dat)) : 8'(dat);
                    end
                    prog_seq++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (prog_seq != seen_seq) begin
            seen_seq = prog_seq;
            busy_cnt = busy_len;
        end else if (busy_cnt > 0) busy_cnt--;
    end

    // ---------------- timing monitors ----------------
    int sk_hi = 0, sk_lo = 0, hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
    int cs_lo = 0, cs_hi = 0, last_gap = 0, last_hi = 0;
    bit after_fall = 0;

    always @(negedge clk) begin
        if (mem_cs) begin
            if (cs_lo != 0) begin last_gap = cs_lo; cs_lo = 0; end
            cs_hi++;
        end else begin
            if (cs_hi != 0) begin last_hi = cs_hi; cs_hi = 0; end
            cs_lo++;
        end
        if (mem_sk) begin
            if (after_fall && sk_lo != 0) begin
                if (sk_lo < lo_min) lo_min = sk_lo;
                if (sk_lo > lo_max) lo_max = sk_lo;
            end
            sk_lo = 0; after_fall = 0;
            sk_hi++;
        end else begin
            if (sk_hi != 0) begin
                if (sk_hi < hi_min) hi_min = sk_hi;
                if (sk_hi > hi_max) hi_max = sk_hi;
                after_fall = mem_cs;
                sk_hi = 0;
            end
            if (!mem_cs) begin after_fall = 0; sk_lo = 0; end
            else if (after_fall) sk_lo++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [15:0] got_rd;
    logic        got_err, busy_seen, done_after;
    int          got_edges;

    task automatic run_cmd(input logic [2:0] c, input int a, input int d, input logic w);
        int e0, n;
        @(negedge clk);
        req_cmd = c; req_addr = 7'(a); req_wdata = 16'(d); req_wide = w; req_valid = 1'b1;
        e0 = tot_edges;
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = !req_ready;
        n = 0;
        while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
        if (!rsp_done) begin
            n_chk++; n_fail++;
            $display("FAIL R8: no done, actual 0 expected 1");
        end
        got_rd = rsp_rdata; got_err = rsp_err; got_edges = tot_edges - e0;
        @(negedge clk);
        done_after = rsp_done;
    endtask

    function automatic int d8(int a);  return (a * 37 + 11) & 255; endfunction
    function automatic int d16(int w); return (w * 4099 + 16'h1234) & 16'hFFFF; endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 ready at reset", 32'(req_ready), 1);
        chk("R1 cs at reset", 32'(mem_cs), 0);
        chk("R1 sk at reset", 32'(mem_sk), 0);
        chk("R1 done at reset", 32'(rsp_done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 ready after reset", 32'(req_ready), 1);

        // Locked write is ignored by the memory; frame fields observed
        run_cmd(3'd1, 5, 8'hAA, 1'b0);
        chk("R1 busy during command", 32'(busy_seen), 1);
        chk("R8 single done pulse", 32'(done_after), 0);
        chk("R3 write frame edges x8", 32'(got_edges), 18);
        chk("R3 start bit", 32'(cap_start), 1);
        chk("R3 write opcode", 32'(cap_op), 1);
        chk("R3 write address", 32'(cap_addr), 5);
        run_cmd(3'd0, 5, 0, 1'b0);
        chk("R5 read edges x8", 32'(got_edges), 19);
        chk("R5 read opcode", 32'(cap_op), 2);
        chk("R5 locked data kept", 32'(got_rd), 32'((5 * 3 + 1) & 255));

        // Unlock sub-code
        run_cmd(3'd5, 0, 0, 1'b0);
        chk("R4 unlock edges", 32'(got_edges), 10);
        chk("R4 unlock field", 32'(cap_addr), 32'h60);

        // Byte-organisation sweep
        for (int a = 0; a < 128; a++) begin
            run_cmd(3'd1, a, d8(a), 1'b0);
            if (a == 0) begin
                chk("R6 settle gap", 32'(last_gap), CS_LOW_CYC);
                chk("R7 no error when ready", 32'(got_err), 0);
            end
        end
        for (int a = 0; a < 128; a++) begin
            run_cmd(3'd0, a, 0, 1'b0);
            chk("R5 byte read", 32'(got_rd), 32'(d8(a)));
        end

        // Word-organisation sweep
        for (int w = 0; w < 64; w++) run_cmd(3'd1, w, d16(w), 1'b1);
        chk("R3 write edges x16", 32'(got_edges), 25);
        for (int w = 0; w < 64; w++) begin
            run_cmd(3'd0, w, 0, 1'b1);
            chk("R5 word read", 32'(got_rd), 32'(d16(w)));
        end
        chk("R5 read edges x16", 32'(got_edges), 26);

        // Erase one word
        run_cmd(3'd2, 10, 0, 1'b1);
        chk("R3 erase opcode", 32'(cap_op), 3);
        chk("R3 erase address", 32'(cap_addr), 10);
        run_cmd(3'd0, 10, 0, 1'b1);
        chk("R6 erased word", 32'(got_rd), 32'hFFFF);
        run_cmd(3'd0, 11, 0, 1'b1);
        chk("R6 neighbour kept", 32'(got_rd), 32'(d16(11)));

        // Write-all, byte mode
        run_cmd(3'd4, 0, 8'h3C, 1'b0);
        chk("R4 fill-all field", 32'(cap_addr), 32'h20);
        chk("R4 fill-all edges", 32'(got_edges), 18);
        chk("R6 fill-all gap", 32'(last_gap), CS_LOW_CYC);
        run_cmd(3'd0, 0, 0, 1'b0);   chk("R4 fill-all addr 0", 32'(got_rd), 32'h3C);
        run_cmd(3'd0, 77, 0, 1'b0);  chk("R4 fill-all addr 77", 32'(got_rd), 32'h3C);
        run_cmd(3'd0, 127, 0, 1'b0); chk("R4 fill-all addr 127", 32'(got_rd), 32'h3C);

        // Erase-all, word mode
        run_cmd(3'd3, 0, 0, 1'b1);
        chk("R4 clear-all field", 32'(cap_addr), 32'h20);
        chk("R4 clear-all edges", 32'(got_edges), 9);
        run_cmd(3'd0, 3, 0, 1'b1);
        chk("R4 cleared word", 32'(got_rd), 32'hFFFF);

        // Lock, then a write has no effect
        run_cmd(3'd6, 0, 0, 1'b1);
        chk("R4 lock field", 32'(cap_addr), 0);
        run_cmd(3'd1, 2, 16'h0000, 1'b1);
        run_cmd(3'd0, 2, 0, 1'b1);
        chk("R4 write after lock ignored", 32'(got_rd), 32'hFFFF);

        // Poll timeout
        run_cmd(3'd5, 0, 0, 1'b0);
        busy_len = POLL_LIMIT + 20;
        run_cmd(3'd1, 1, 8'h11, 1'b0);
        chk("R7 timeout error", 32'(got_err), 1);
        chk("R7 poll window", 32'(last_hi), POLL_LIMIT);
        chk("R8 error cleared after pulse", 32'(rsp_err), 0);
        busy_len = 3;
        run_cmd(3'd1, 1, 8'h22, 1'b0);
        chk("R6 ready after busy", 32'(got_err), 0);
        run_cmd(3'd0, 1, 0, 1'b0);
        chk("R5 read after recovery", 32'(got_rd), 32'h22);
        chk("R8 rdata held", 32'(rsp_rdata), 32'h22);

        // Serial clock phases
        chk("R2 high phase min", 32'(hi_min), CLK_DIV);
        chk("R2 high phase max", 32'(hi_max), CLK_DIV);
        chk("R2 low phase min", 32'(lo_min), CLK_DIV);
        chk("R2 low phase max", 32'(lo_max), CLK_DIV);

        summary();
        $finish;
    end
endmodule